// File: doc/BRIEF.md
# SAR ADC conversion controller

This block is the digital sequencer for a successive-approximation analog-to-digital converter. It drives the trial code of an external DAC and the track/hold control of an external sample-and-hold. It reads a one-bit comparator decision once per comparison and resolves one result bit per cycle, most significant bit first. It delivers the finished code together with a one-cycle done strobe.

When the enable input rises, the controller runs one throw-away conversion on its own and does not report its result. A settle timer also starts at enable. The ready flag rises only after the throw-away conversion has finished and the programmed number of settle cycles has elapsed. From then on, each accepted start request produces one sample cycle followed by the comparison cycles. While the track/hold output is low, the DAC code stays at mid-scale.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, dac_o is 0x200 (mid-scale), hold_o is 0, ready_o is 0, done_o is 0 and result_o is 0.
- R2: Whenever hold_o is 0, dac_o equals the mid-scale code 0x200.
- R3: Bits are resolved from bit 9 down to bit 0. In each comparison cycle, dac_o equals the bits already kept with the bit under test also set to 1. That bit is kept when cmp_i is 1 in that cycle and cleared otherwise. With a comparator that is 1 when the input is at or above dac_o, the result equals the input code.
- R4: A conversion is one sample cycle (hold_o 0) followed by exactly 10 comparison cycles with hold_o 1. In the cycle after the bit-0 comparison, hold_o is 0 and, for a reported conversion, done_o is 1.
- R5: done_o is never high for two cycles in a row.
- R6: The rise of en_i starts a dummy conversion without any start request. The dummy conversion raises no done_o and leaves result_o unchanged.
- R7: ready_o rises only when both of these hold: the dummy conversion has completed, and SETTLE_CYCLES clock edges with en_i high have elapsed since enable. result_o changes only in a cycle where done_o is 1.
- R8: start_i is accepted only when ready_o is 1 and no conversion is running. A start during a conversion, or before ready_o, has no effect.
- R9: A low en_i ends any activity at the next edge: hold_o goes low, dac_o returns to mid-scale and ready_o clears. A later enable runs a new dummy conversion and restarts the settle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Converter enable |
| start_i | input | 1 | Start-conversion request |
| cmp_i | input | 1 | Comparator decision, 1 when the input is at or above the DAC level |
| dac_o | output | 10 | DAC trial code |
| hold_o | output | 1 | 1 while holding (comparison phase), 0 while sampling or idle |
| ready_o | output | 1 | Dummy conversion done and settle time elapsed |
| done_o | output | 1 | One-cycle strobe for a new valid result |
| result_o | output | 10 | Last valid conversion result |

## Verification
A wrong bit index or a corrupted kept-bit register shows up on dac_o in the very next comparison cycle, long before the result is delivered. A behavioural model that follows the trial codes therefore catches it within one clock. A dummy flag that is wrongly cleared or set shows up either as a done strobe about eleven cycles after enable or as a missing strobe after a start. A miscounting settle timer moves the rise of ready_o away from the expected edge. A state machine that accepts starts it should ignore shifts the done strobe or the hold window by at least one cycle.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_IDLE = 2'd1,
    ST_SAMP = 2'd2,
    ST_CONV = 2'd3
  } sar_state_e;
endpackage

// File: rtl/sar_settle_timer.sv
module sar_settle_timer #(
  parameter int unsigned SETTLE_CYCLES = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic settled_o
);
  localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign settled_o = (cnt_q == LIMIT);

  a_r7_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
  a_r9_clear_on_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_pkg::*;
#(
  parameter int unsigned NBITS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             cmp_i,
  input  logic             settled_i,
  output logic [NBITS-1:0] dac_o,
  output logic             hold_o,
  output logic             ready_o,
  output logic             done_o,
  output logic [NBITS-1:0] result_o
);
  localparam int unsigned BW = $clog2(NBITS);
  localparam logic [NBITS-1:0] MID = NBITS'(1) << (NBITS - 1);
  localparam logic [BW-1:0] TOP_BIT = BW'(NBITS - 1);

  sar_state_e       state_q;
  logic [BW-1:0]    bit_q;
  logic [NBITS-1:0] acc_q, trial, acc_next, result_q;
  logic             dummy_q, dummy_done_q, done_q;

  assign trial    = acc_q | (NBITS'(1) << bit_q);
  assign acc_next = cmp_i ? trial : acc_q;
  assign ready_o  = dummy_done_q & settled_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_OFF;
      bit_q        <= '0;
      acc_q        <= '0;
      dummy_q      <= 1'b0;
      dummy_done_q <= 1'b0;
      done_q       <= 1'b0;
      result_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        state_q      <= ST_OFF;
        dummy_done_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_OFF: begin
            state_q <= ST_SAMP;
            dummy_q <= 1'b1;
          end
          ST_IDLE: if (start_i && ready_o) begin
            state_q <= ST_SAMP;
            dummy_q <= 1'b0;
          end
          ST_SAMP: begin
            state_q <= ST_CONV;
            bit_q   <= TOP_BIT;
            acc_q   <= '0;
          end
          ST_CONV: begin
            acc_q <= acc_next;
            if (bit_q == '0) begin
              state_q <= ST_IDLE;
              if (dummy_q) dummy_done_q <= 1'b1;
              else begin
                result_q <= acc_next;
                done_q   <= 1'b1;
              end
            end else begin
              bit_q <= bit_q - 1'b1;
            end
          end
          default: state_q <= ST_OFF;
        endcase
      end
    end
  end

  assign hold_o   = (state_q == ST_CONV);
  assign dac_o    = hold_o ? trial : MID;
  assign done_o   = done_q;
  assign result_o = result_q;

  a_r2_mid_while_sampling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_o |-> dac_o == MID);
  a_r4_hold_drops_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !hold_o && $past(hold_o));
  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_result_only_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> $stable(result_o) || done_o);
  a_r8_no_restart_in_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && en_i && bit_q != '0) |=> hold_o);
  a_r9_disable_quiets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !hold_o && !ready_o);
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int unsigned NBITS         = 10,
  parameter int unsigned SETTLE_CYCLES = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic [NBITS-1:0] dac_o,
  output logic             hold_o,
  output logic             ready_o,
  output logic             done_o,
  output logic [NBITS-1:0] result_o
);
  logic settled;

  sar_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .settled_o(settled)
  );

  sar_sequencer #(.NBITS(NBITS)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .start_i  (start_i),
    .cmp_i    (cmp_i),
    .settled_i(settled),
    .dac_o    (dac_o),
    .hold_o   (hold_o),
    .ready_o  (ready_o),
    .done_o   (done_o),
    .result_o (result_o)
  );

  a_r7_ready_needs_settle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> settled);
endmodule

// File: tb/test_sar_adc_ctrl.sv
`timescale 1ns/1ps
module test_sar_adc_ctrl;
  localparam int SETTLE = 50;
  localparam int MIDV   = 512;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0, start_i = 1'b0, cmp_i;
  logic [9:0] dac_o, result_o;
  logic hold_o, ready_o, done_o;
  int vin = 0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;
  assign cmp_i = (vin >= int'(dac_o));

  sar_adc_ctrl #(.NBITS(10), .SETTLE_CYCLES(SETTLE)) i_sar_adc_ctrl (
    .clk_i, .rst_ni, .en_i, .start_i, .cmp_i,
    .dac_o, .hold_o, .ready_o, .done_o, .result_o
  );

  // behavioural reference: 0 off, 1 idle, 2 sample, 3 compare
  int m_st = 0, m_bit = 0, m_acc = 0, m_res = 0, m_cnt = 0;
  bit m_dummy = 0, m_ddone = 0, m_done = 0;

  function automatic bit m_ready();
    return m_ddone && (m_cnt == SETTLE);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_acc = 0; m_res = 0; m_cnt = 0; m_ddone = 0; m_done = 0; m_dummy = 0;
    end else begin
      bit rdy;
      rdy = m_ready();
      m_done = 0;
      if (!en_i) begin
        m_st = 0; m_ddone = 0; m_cnt = 0;
      end else begin
        if (m_cnt < SETTLE) m_cnt++;
        case (m_st)
          0: begin m_st = 2; m_dummy = 1; end
          1: if (start_i && rdy) begin m_st = 2; m_dummy = 0; end
          2: begin m_st = 3; m_bit = 9; m_acc = 0; end
          default: begin
            int t;
            t = m_acc + (1 << m_bit);
            if (vin >= t) m_acc = t;
            if (m_bit == 0) begin
              m_st = 1;
              if (m_dummy) m_ddone = 1;
              else begin m_res = m_acc; m_done = 1; end
            end else m_bit--;
          end
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk_i) if (rst_ni && !finished) begin
    int edac;
    edac = (m_st == 3) ? (m_acc + (1 << m_bit)) : MIDV;
    chk(int'(dac_o) == edac, "R3 dac", int'(dac_o), edac);
    chk(hold_o == (m_st == 3), "R4 hold", hold_o, int'(m_st == 3));
    chk(done_o == m_done, "R5 done", done_o, m_done);
    chk(int'(result_o) == m_res, "R7 result", int'(result_o), m_res);
    chk(ready_o == m_ready(), "R7 ready", ready_o, m_ready());
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
    #0.5;
  endtask

  task automatic convert(input int v, input bit poke_mid);
    int seen = 0;
    vin = v;
    start_i = 1'b1; step(1); start_i = 1'b0;
    if (poke_mid) begin step(4); start_i = 1'b1; step(1); start_i = 1'b0; end
    for (int i = 0; i < 30 && seen == 0; i++) begin
      step(1);
      if (done_o) seen = 1;
    end
    chk(seen == 1, "R4 done seen", seen, 1);
    chk(int'(result_o) == v, "R3 result equals input", int'(result_o), v);
    step(1);
    chk(done_o == 1'b0, "R5 done one cycle", done_o, 0);
  endtask

  initial begin
    int dones;
    #1;
    chk(dac_o == 10'h200, "R1 dac reset", dac_o, 512);
    chk(hold_o == 0 && ready_o == 0 && done_o == 0, "R1 ctrl reset", hold_o, 0);
    chk(result_o == 0, "R1 result reset", result_o, 0);
    step(2); rst_ni = 1'b1; step(2);

    // R6: dummy conversion on enable, starts ignored before ready (R8)
    vin = 300; en_i = 1'b1;
    dones = 0;
    for (int i = 0; i < SETTLE + 5; i++) begin
      start_i = (i % 7 == 3);
      step(1);
      if (done_o) dones++;
    end
    start_i = 1'b0;
    chk(dones == 0, "R6 no done from dummy", dones, 0);
    chk(result_o == 0, "R6 result untouched", result_o, 0);
    chk(ready_o == 1, "R7 ready after settle", ready_o, 1);

    convert(0, 0);
    convert(1023, 0);
    convert(512, 0);
    convert(511, 0);
    convert(291, 1);   // R8 start during conversion ignored
    convert(323, 0);
    convert(341, 1);

    // R9: disable mid conversion, then re-enable
    vin = 700; start_i = 1'b1; step(1); start_i = 1'b0; step(3);
    en_i = 1'b0; step(1);
    chk(hold_o == 0 && dac_o == 10'h200, "R9 quiet after disable", hold_o, 0);
    chk(ready_o == 0, "R9 ready cleared", ready_o, 0);
    step(3); en_i = 1'b1;
    dones = 0;
    for (int i = 0; i < SETTLE + 3; i++) begin
      start_i = 1'b1; step(1);
      if (done_o) dones++;
      if (ready_o) break;
    end
    start_i = 1'b0;
    chk(dones == 0, "R6 re-enable dummy silent", dones, 0);
    step(2);
    convert(777, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule